// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Register

This block is the storage element of one logic cell in a small programmable logic device. One run-time setting chooses how the register reacts to a clock event: as a D, T, JK or SR flip-flop. A bypass setting takes the register out of the path so the combinational input reaches the output directly. A second setting picks the clocking scheme. The event can come from a selectable global clock, from the same clock qualified by an enable produced in logic, or from a clock signal generated inside the logic array.

Each global clock source is built from any of the global clock pins, in true or inverted form. Asynchronous controls are layered on top of the clocked behaviour. Preset and clear are active high and clear has priority. A dedicated active-low global clear overrides both. A synchronous reset loads the configured power-up value. A second flip-flop gives the fast-input path: it captures a pin value on every clock event, and the flip-flop type and the bypass setting have no effect on it.

The whole cell runs on one system clock `clk`. The clock pins and the array clock are sampled on it. A rising edge of the selected clock level is a clock event. The register acts on the first `clk` rising edge at which it sees the new level.

Top module: `mc_cell_reg`

## Requirements
- R1: With `ffType`=00 (D), a clock event loads `dIn` into the register.
- R2: With `ffType`=01 (T), a clock event inverts the register when `dIn`=1 and leaves it unchanged when `dIn`=0.
- R3: With `ffType`=10 (JK, `dIn`=J, `kIn`=K), a clock event applies: 00 hold, 01 clear, 10 set, 11 toggle.
- R4: With `ffType`=11 (SR, `dIn`=S, `kIn`=R), a clock event applies: 10 set, 01 clear, 00 and 11 hold.
- R5: While `bypass`=1, `qOut` equals `combIn` in the same cycle. When `bypass` returns to 0, the stored value shows again.
- R6: A clock event is a rising edge of the selected global clock level when `clkMode` is 00 or the reserved 11. With 01 it is such an edge only while `clkEn`=1. With 10 it is a rising edge of `arrayClk`, and global edges are ignored.
- R7: Global clock source i has the level `gclkPin[gclkSrcPin[i]]` XOR `gclkInv[i]`, and `gclkSel` picks the source that is used. An inverted source therefore clocks on the falling pin edge.
- R8: `asyncClr`=1 forces the register to 0 and `asyncPre`=1 forces it to 1, without waiting for a clock. When both are high the register is 0.
- R9: `gClrN`=0 forces both the register and `fastQ` to 0 asynchronously and overrides `asyncPre`.
- R10: `syncRst`=1 loads the power-up value: 1 when `INIT_HIGH`=1, except that the `FORCE_LOW`=1 variant always loads 0. `fastQ` resets to 0.
- R11: `fastQ` captures `fastPin` on every clock event, whatever `ffType` and `bypass` are.
- R12: When there is no clock event and no asynchronous control is active, the register keeps its value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all pins are sampled |
| syncRst | input | 1 | Synchronous reset, loads the power-up value |
| gclkPin | input | PIN_COUNT | Global clock pins |
| gclkSrcPin | input | NUM_GCLK x clog2(PIN_COUNT) | Pin index for each global clock source |
| gclkInv | input | NUM_GCLK | Inversion for each global clock source |
| gclkSel | input | clog2(NUM_GCLK) | Global clock source used by this cell |
| clkMode | input | 2 | 00 global, 01 gated global, 10 array, 11 as global |
| clkEn | input | 1 | Active-high clock enable for gated mode |
| arrayClk | input | 1 | Clock signal from the logic array |
| ffType | input | 2 | 00 D, 01 T, 10 JK, 11 SR |
| bypass | input | 1 | Sends combIn straight to qOut |
| dIn | input | 1 | D, T, J or S input |
| kIn | input | 1 | K or R input |
| combIn | input | 1 | Combinational logic input |
| asyncPre | input | 1 | Active-high asynchronous preset |
| asyncClr | input | 1 | Active-high asynchronous clear |
| gClrN | input | 1 | Active-low global clear |
| fastPin | input | 1 | Pin value for the fast-input flip-flop |
| qOut | output | 1 | Cell output |
| fastQ | output | 1 | Fast-input flip-flop output |

## Verification
On every cycle the assertions check the asynchronous layering: clear forces 0, preset alone forces 1, the global clear empties both flip-flops, and the register holds when there is no event. They also check that a JK toggle changes the state and that an array-mode event always comes from an `arrayClk` rise. Only the bench scenarios can show that each flip-flop type follows its full truth table and that bypass is transparent and then gives back the stored value. The same goes for choosing and inverting a clock source, which changes which pin edge counts, for the gating by `clkEn`, and for the two power-up variants.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ffType_e;

  typedef enum logic [1:0] {
    CM_GLOBAL = 2'b00,
    CM_GATED  = 2'b01,
    CM_ARRAY  = 2'b10,
    CM_RSVD   = 2'b11
  } clkMode_e;

  // strobes from the clock/control unit to the storage datapath
  typedef struct packed {
    logic tick;    // clock event this cycle
    logic load;    // synchronous load of power-up value
    logic clrA;    // asynchronous clear of the cell register
    logic setA;    // asynchronous preset, already masked by clear
    logic gclr;    // global clear, also empties the fast flop
  } ctrlStrobe_t;

endpackage

// File: rtl/mc_clk_ctrl.sv
module mc_clk_ctrl
  import mc_pkg::*;
#(
  parameter int PIN_COUNT = 2,
  parameter int NUM_GCLK  = 2
) (
  input  logic                                         clk,
  input  logic                                         syncRst,
  input  logic [PIN_COUNT-1:0]                         gclkPin,
  input  logic [NUM_GCLK-1:0][$clog2(PIN_COUNT)-1:0]   gclkSrcPin,
  input  logic [NUM_GCLK-1:0]                          gclkInv,
  input  logic [$clog2(NUM_GCLK)-1:0]                  gclkSel,
  input  logic [1:0]                                   clkMode,
  input  logic                                         clkEn,
  input  logic                                         arrayClk,
  input  logic                                         asyncPre,
  input  logic                                         asyncClr,
  input  logic                                         gClrN,
  output ctrlStrobe_t                                  strb
);

  logic [NUM_GCLK-1:0] srcLvl;
  logic selLvl, gLvlQ, aLvlQ, gRise, aRise, tick, clrAny;
  clkMode_e modeSel;

  // build every global clock source from a pin and a polarity
  generate
    for (genvar g = 0; g < NUM_GCLK; g++) begin : gSrc
      assign srcLvl[g] = gclkPin[gclkSrcPin[g]] ^ gclkInv[g];
    end
  endgenerate

  assign selLvl = srcLvl[gclkSel];

  always_ff @(posedge clk) begin
    gLvlQ <= selLvl;
    aLvlQ <= arrayClk;
  end

  assign gRise   = selLvl & ~gLvlQ;
  assign aRise   = arrayClk & ~aLvlQ;
  assign modeSel = clkMode_e'(clkMode);

  always_comb begin
    unique case (modeSel)
      CM_GLOBAL: tick = gRise;
      CM_GATED:  tick = gRise & clkEn;
      CM_ARRAY:  tick = aRise;
      default:   tick = gRise;
    endcase
  end

  assign clrAny = asyncClr | ~gClrN;

  always_comb begin
    strb.tick = tick & ~syncRst;
    strb.load = syncRst;
    strb.clrA = clrAny;
    strb.setA = asyncPre & ~clrAny;
    strb.gclr = ~gClrN;
  end

  // an array-mode event must come from a rise seen on the array clock
  assert_array_src_R6: assert property (@(posedge clk) disable iff (syncRst)
    (clkMode == CM_ARRAY && strb.tick) |-> (arrayClk && !$past(arrayClk)));

endmodule

// File: rtl/mc_store_dp.sv
module mc_store_dp
  import mc_pkg::*;
#(
  parameter logic INIT_VAL = 1'b1
) (
  input  logic        clk,
  input  ctrlStrobe_t strb,
  input  logic [1:0]  ffType,
  input  logic        dIn,
  input  logic        kIn,
  input  logic        combIn,
  input  logic        bypass,
  input  logic        fastPin,
  output logic        qOut,
  output logic        fastQ
);

  logic regQ, nextQ, clrA, setA, gclr, tick, load;
  ffType_e typeSel;

  assign clrA    = strb.clrA;
  assign setA    = strb.setA;
  assign gclr    = strb.gclr;
  assign tick    = strb.tick;
  assign load    = strb.load;
  assign typeSel = ffType_e'(ffType);

  always_comb begin
    unique case (typeSel)
      FF_D:  nextQ = dIn;
      FF_T:  nextQ = regQ ^ dIn;
      FF_JK: begin
        unique case ({dIn, kIn})
          2'b00:   nextQ = regQ;
          2'b01:   nextQ = 1'b0;
          2'b10:   nextQ = 1'b1;
          default: nextQ = ~regQ;
        endcase
      end
      default: begin
        unique case ({dIn, kIn})
          2'b10:   nextQ = 1'b1;
          2'b01:   nextQ = 1'b0;
          default: nextQ = regQ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or posedge clrA or posedge setA) begin
    if (clrA)      regQ <= 1'b0;
    else if (setA) regQ <= 1'b1;
    else if (load) regQ <= INIT_VAL;
    else if (tick) regQ <= nextQ;
  end

  always_ff @(posedge clk or posedge gclr) begin
    if (gclr)      fastQ <= 1'b0;
    else if (load) fastQ <= 1'b0;
    else if (tick) fastQ <= fastPin;
  end

  assign qOut = bypass ? combIn : regQ;

  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (load)
    clrA |-> (regQ == 1'b0));

  assert_pre_sets_R8: assert property (@(posedge clk) disable iff (load)
    setA |-> (regQ == 1'b1));

  assert_gclr_both_R9: assert property (@(posedge clk) disable iff (load)
    gclr |-> (regQ == 1'b0 && fastQ == 1'b0));

  assert_jk_toggle_R3: assert property (@(posedge clk) disable iff (load)
    (tick && typeSel == FF_JK && dIn && kIn && !clrA && !setA)
      |=> (clrA || setA || load || regQ != $past(regQ)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (load)
    (!tick && !clrA && !setA) |=> (clrA || setA || load || regQ == $past(regQ)));

endmodule

// File: rtl/mc_cell_reg.sv
module mc_cell_reg
  import mc_pkg::*;
#(
  parameter int PIN_COUNT = 2,
  parameter int NUM_GCLK  = 2,
  parameter bit INIT_HIGH = 1'b1,
  parameter bit FORCE_LOW = 1'b0
) (
  input  logic                                         clk,
  input  logic                                         syncRst,
  input  logic [PIN_COUNT-1:0]                         gclkPin,
  input  logic [NUM_GCLK-1:0][$clog2(PIN_COUNT)-1:0]   gclkSrcPin,
  input  logic [NUM_GCLK-1:0]                          gclkInv,
  input  logic [$clog2(NUM_GCLK)-1:0]                  gclkSel,
  input  logic [1:0]                                   clkMode,
  input  logic                                         clkEn,
  input  logic                                         arrayClk,
  input  logic [1:0]                                   ffType,
  input  logic                                         bypass,
  input  logic                                         dIn,
  input  logic                                         kIn,
  input  logic                                         combIn,
  input  logic                                         asyncPre,
  input  logic                                         asyncClr,
  input  logic                                         gClrN,
  input  logic                                         fastPin,
  output logic                                         qOut,
  output logic                                         fastQ
);

  // the fixed-low variant ignores the configured power-up value
  localparam logic INIT_VAL = FORCE_LOW ? 1'b0 : logic'(INIT_HIGH);

  ctrlStrobe_t strb;

  mc_clk_ctrl #(.PIN_COUNT(PIN_COUNT), .NUM_GCLK(NUM_GCLK)) uCtrl (
    .clk(clk), .syncRst(syncRst), .gclkPin(gclkPin), .gclkSrcPin(gclkSrcPin),
    .gclkInv(gclkInv), .gclkSel(gclkSel), .clkMode(clkMode), .clkEn(clkEn),
    .arrayClk(arrayClk), .asyncPre(asyncPre), .asyncClr(asyncClr),
    .gClrN(gClrN), .strb(strb)
  );

  mc_store_dp #(.INIT_VAL(INIT_VAL)) uData (
    .clk(clk), .strb(strb), .ffType(ffType), .dIn(dIn), .kIn(kIn),
    .combIn(combIn), .bypass(bypass), .fastPin(fastPin),
    .qOut(qOut), .fastQ(fastQ)
  );

endmodule

// File: tb/tb_mc_cell_reg.sv
module tb_mc_cell_reg;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic syncRst, clkEn, arrayClk, bypass, dIn, kIn, combIn;
  logic asyncPre, asyncClr, gClrN, fastPin;
  logic [1:0] gclkPin, gclkInv, clkMode, ffType;
  logic [1:0][0:0] gclkSrcPin;
  logic [0:0] gclkSel;
  logic qOut, fastQ, qLow, fastLow;

  mc_cell_reg dut (
    .clk(clk), .syncRst(syncRst), .gclkPin(gclkPin), .gclkSrcPin(gclkSrcPin),
    .gclkInv(gclkInv), .gclkSel(gclkSel), .clkMode(clkMode), .clkEn(clkEn),
    .arrayClk(arrayClk), .ffType(ffType), .bypass(bypass), .dIn(dIn),
    .kIn(kIn), .combIn(combIn), .asyncPre(asyncPre), .asyncClr(asyncClr),
    .gClrN(gClrN), .fastPin(fastPin), .qOut(qOut), .fastQ(fastQ)
  );

  mc_cell_reg #(.FORCE_LOW(1'b1)) dutLow (
    .clk(clk), .syncRst(syncRst), .gclkPin(gclkPin), .gclkSrcPin(gclkSrcPin),
    .gclkInv(gclkInv), .gclkSel(gclkSel), .clkMode(clkMode), .clkEn(clkEn),
    .arrayClk(arrayClk), .ffType(ffType), .bypass(bypass), .dIn(dIn),
    .kIn(kIn), .combIn(combIn), .asyncPre(asyncPre), .asyncClr(asyncClr),
    .gClrN(gClrN), .fastPin(fastPin), .qOut(qLow), .fastQ(fastLow)
  );

  typedef struct {
    string tag;
    logic  expQ;
    logic  expF;
    bit    useF;
    bit    useLow;
    logic  expLow;
  } expItem_t;

  expItem_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: compares queued expectations after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        checks++;
        if (qOut !== it.expQ) begin
          errors++;
          $display("FAIL %s qOut actual %b expected %b", it.tag, qOut, it.expQ);
        end
        if (it.useF) begin
          checks++;
          if (fastQ !== it.expF) begin
            errors++;
            $display("FAIL %s fastQ actual %b expected %b", it.tag, fastQ, it.expF);
          end
        end
        if (it.useLow) begin
          checks++;
          if (qLow !== it.expLow) begin
            errors++;
            $display("FAIL %s low-variant qOut actual %b expected %b", it.tag, qLow, it.expLow);
          end
        end
      end
    end
  end

  task automatic pushExp(string tag, logic q, logic f = 1'b0, bit useF = 1'b0,
                         bit useLow = 1'b0, logic expLow = 1'b0);
    expItem_t it;
    #1;
    it.tag = tag; it.expQ = q; it.expF = f; it.useF = useF;
    it.useLow = useLow; it.expLow = expLow;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic pinPulse(int idx);
    @(negedge clk); gclkPin[idx] = 1'b1;
    @(negedge clk); gclkPin[idx] = 1'b0;
  endtask

  task automatic arrayPulse();
    @(negedge clk); arrayClk = 1'b1;
    @(negedge clk); arrayClk = 1'b0;
  endtask

  initial begin
    syncRst = 1'b1; clkEn = 1'b0; arrayClk = 1'b0; bypass = 1'b0;
    dIn = 1'b0; kIn = 1'b0; combIn = 1'b0; asyncPre = 1'b0; asyncClr = 1'b0;
    gClrN = 1'b1; fastPin = 1'b0; gclkPin = '0; gclkInv = '0;
    clkMode = 2'b00; ffType = 2'b00; gclkSrcPin[0] = 1'b0; gclkSrcPin[1] = 1'b1;
    gclkSel = 1'b0;
    repeat (3) @(negedge clk);
    syncRst = 1'b0;
    pushExp("R10 power-up value", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    // R1 D flip-flop and R11 fast path
    dIn = 1'b0; pinPulse(0); pushExp("R1 D load 0", 1'b0);
    dIn = 1'b1; fastPin = 1'b1; pinPulse(0); pushExp("R1 D load 1 / R11 fast", 1'b1, 1'b1, 1'b1);
    dIn = 1'b0; repeat (3) @(negedge clk); pushExp("R12 hold without event", 1'b1);

    // R2 toggle
    ffType = 2'b01; dIn = 1'b1;
    pinPulse(0); pushExp("R2 T toggle to 0", 1'b0);
    pinPulse(0); pushExp("R2 T toggle to 1", 1'b1);
    dIn = 1'b0; pinPulse(0); pushExp("R2 T hold", 1'b1);

    // R3 JK truth table
    ffType = 2'b10;
    dIn = 1'b1; kIn = 1'b1; pinPulse(0); pushExp("R3 JK 11 toggle", 1'b0);
    dIn = 1'b1; kIn = 1'b0; pinPulse(0); pushExp("R3 JK 10 set", 1'b1);
    dIn = 1'b0; kIn = 1'b1; pinPulse(0); pushExp("R3 JK 01 clear", 1'b0);
    dIn = 1'b0; kIn = 1'b0; pinPulse(0); pushExp("R3 JK 00 hold", 1'b0);
    dIn = 1'b1; kIn = 1'b1; pinPulse(0); pushExp("R3 JK 11 toggle back", 1'b1);

    // R4 SR truth table
    ffType = 2'b11;
    dIn = 1'b0; kIn = 1'b1; pinPulse(0); pushExp("R4 SR reset", 1'b0);
    dIn = 1'b1; kIn = 1'b1; pinPulse(0); pushExp("R4 SR 11 holds 0", 1'b0);
    dIn = 1'b1; kIn = 1'b0; pinPulse(0); pushExp("R4 SR set", 1'b1);
    dIn = 1'b1; kIn = 1'b1; pinPulse(0); pushExp("R4 SR 11 holds 1", 1'b1);

    // R5 bypass, R11 fast flop unaffected by type and bypass
    bypass = 1'b1; combIn = 1'b0; pushExp("R5 bypass passes 0", 1'b0);
    combIn = 1'b1; pushExp("R5 bypass passes 1", 1'b1);
    fastPin = 1'b0; combIn = 1'b0; pinPulse(0);
    pushExp("R11 fast flop in bypass", 1'b0, 1'b0, 1'b1);
    fastPin = 1'b1; bypass = 1'b0; pushExp("R5 stored value returns", 1'b1);

    // R6 clock modes
    ffType = 2'b00; clkMode = 2'b01; dIn = 1'b0; clkEn = 1'b0;
    pinPulse(0); pushExp("R6 gated, enable low", 1'b1);
    clkEn = 1'b1; pinPulse(0); pushExp("R6 gated, enable high", 1'b0);
    clkMode = 2'b10; dIn = 1'b1;
    pinPulse(0); pushExp("R6 array ignores global", 1'b0);
    arrayPulse(); pushExp("R6 array clock", 1'b1);
    clkMode = 2'b11; dIn = 1'b0; pinPulse(0); pushExp("R6 reserved acts global", 1'b0);

    // R7 source selection and inversion
    clkMode = 2'b00; dIn = 1'b0;
    gclkInv[1] = 1'b1; gclkSel = 1'b1;
    repeat (2) @(negedge clk);
    pushExp("R7 switch source", 1'b0);
    dIn = 1'b1; pinPulse(0); pushExp("R7 unselected pin ignored", 1'b0);
    @(negedge clk); gclkPin[1] = 1'b1;
    pushExp("R7 inverted source, pin rise no event", 1'b0);
    gclkPin[1] = 1'b0;
    pushExp("R7 inverted source, pin fall clocks", 1'b1);
    gclkSel = 1'b0; repeat (2) @(negedge clk);

    // R8 asynchronous preset and clear
    asyncClr = 1'b1; pushExp("R8 clear", 1'b0);
    asyncPre = 1'b1; pushExp("R8 clear beats preset", 1'b0);
    asyncClr = 1'b0; pushExp("R8 preset", 1'b1);
    asyncPre = 1'b0; pushExp("R8 released holds", 1'b1);

    // R9 global clear
    asyncPre = 1'b1; gClrN = 1'b0;
    pushExp("R9 global clear over preset", 1'b0, 1'b0, 1'b1);
    gClrN = 1'b1; pushExp("R9 released, preset active", 1'b1);
    asyncPre = 1'b0; pushExp("R9 final hold", 1'b1);

    // R10 reset reload on both variants
    syncRst = 1'b1; @(negedge clk); syncRst = 1'b0;
    pushExp("R10 reset reload", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule